// File: doc/BRIEF.md
# PCI Target Configuration Header

This block holds the type-0 configuration header of a PCI target. A simple synchronous register port reaches it, and it does not use full bus signalling. The port carries a byte offset with the two low bits ignored, a write strobe with 32 bits of write data, and a read strobe. Read data is registered and appears one clock after the read strobe. The data then holds until the next read.

The header contains fixed identification words and a command register in which the I/O-space and memory-space enable bits are writable. It also contains a writable interrupt line byte and two base address registers that follow the write-all-ones sizing rule. The first base register claims an I/O window and the second claims a memory window. Each window is 2^IO_WIN_LOG2 or 2^MEM_WIN_LOG2 bytes.

The block drives the programmed bases and both enable bits on output ports. It also compares an incoming bus address against each base and raises a per-window hit when the matching enable bit is set. Every offset that is not implemented reads as zero, and writes to such offsets change nothing.

Top module: `pci_cfg_space`

## Requirements
- R1: Offset 0x00 reads 0x0120_1022, with the device ID in bits 31:16 and the vendor ID in bits 15:0. Offset 0x08 reads 0x0580_0001, with the class code in bits 31:8 and the revision in bits 7:0. Offset 0x2C reads 0x0120_1022. Offset 0x0C reads zero. Writes to these offsets leave them unchanged.
- R2: Offset 0x04 reads 0x0400_0000 after reset. Bit 0 (I/O-space enable) and bit 1 (memory-space enable) are the only writable bits. After 0x0000_0003 is written, the offset reads 0x0400_0003.
- R3: The I/O base at offset 0x10 has bit 0 hardwired to 1 and bits 19:1 hardwired to 0. Bits 31:20 are writable. Writing all ones makes it read 0xFFF0_0001.
- R4: The memory base at offset 0x14 has bits 19:0 hardwired to 0, so bits 3:0 mark a non-prefetchable 32-bit memory window. Writing all ones makes it read 0xFFF0_0000.
- R5: Offset 0x3C reads max latency and min grant as zero and the interrupt pin as 0x01 in bits 15:8. Bits 7:0 (interrupt line) are fully writable, and writing 0xFF makes the offset read 0x0000_01FF.
- R6: Offset 0x18, offset 0x30 and every other unimplemented offset read zero, and writes to them are ignored.
- R7: io_hit is high only when I/O-space enable is set and bus_addr[31:20] equals the I/O base bits 31:20.
- R8: mem_hit is high only when memory-space enable is set and bus_addr[31:20] equals the memory base bits 31:20.
- R9: cfg_rdata takes the addressed word on the clock edge where cfg_rd is sampled high, and it holds its value while cfg_rd is low. The offset bits 1:0 are ignored.
- R10: A low rst_n on a clock edge clears both enable bits, the interrupt line, the writable base bits and cfg_rdata.
- R11: io_base, mem_base, io_space_en and mem_space_en always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Byte offset of the register; bits 1:0 ignored |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| bus_addr | input | 32 | Bus address to decode |
| io_base | output | 32 | Current I/O base register value |
| mem_base | output | 32 | Current memory base register value |
| io_space_en | output | 1 | Command bit 0 |
| mem_space_en | output | 1 | Command bit 1 |
| io_hit | output | 1 | bus_addr falls in the enabled I/O window |
| mem_hit | output | 1 | bus_addr falls in the enabled memory window |

## Verification
The bench builds the block with its default parameters. Both windows are 2^20 bytes, and the identification words match the values listed above. With these settings the all-ones sizing readbacks become 0xFFF0_0001 and 0xFFF0_0000. The boundary of a window can then be probed with a fixed address just past 1 MB above the base. The decode checks run both before and after the enable bits are written, so the gating of each hit can be seen at the ports.

// File: rtl/pci_cfg_space.sv
module pci_cfg_space #(
  parameter int          IO_WIN_LOG2  = 20,
  parameter int          MEM_WIN_LOG2 = 20,
  parameter logic [15:0] VENDOR_ID    = 16'h1022,
  parameter logic [15:0] DEVICE_ID    = 16'h0120,
  parameter logic [15:0] SUB_VENDOR   = 16'h1022,
  parameter logic [15:0] SUB_DEVICE   = 16'h0120,
  parameter logic [15:0] STATUS_WORD  = 16'h0400,
  parameter logic [23:0] CLASS_CODE   = 24'h058000,
  parameter logic [7:0]  REVISION     = 8'h01,
  parameter logic [7:0]  INT_PIN      = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_addr,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_rd,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] bus_addr,
  output logic [31:0] io_base,
  output logic [31:0] mem_base,
  output logic        io_space_en,
  output logic        mem_space_en,
  output logic        io_hit,
  output logic        mem_hit
);
  localparam int IO_HI  = 32 - IO_WIN_LOG2;
  localparam int MEM_HI = 32 - MEM_WIN_LOG2;
  localparam logic [5:0] W_ID   = 6'h00;
  localparam logic [5:0] W_CMD  = 6'h01;
  localparam logic [5:0] W_CLS  = 6'h02;
  localparam logic [5:0] W_BAR0 = 6'h04;
  localparam logic [5:0] W_BAR1 = 6'h05;
  localparam logic [5:0] W_SUB  = 6'h0B;
  localparam logic [5:0] W_INT  = 6'h0F;

  logic [5:0]        word;
  logic [1:0]        cmd;
  logic [7:0]        int_line;
  logic [IO_HI-1:0]  io_bar;
  logic [MEM_HI-1:0] mem_bar;
  logic [31:0]       rd_mux;

  assign word = cfg_addr[7:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= '0;
      int_line <= '0;
      io_bar   <= '0;
      mem_bar  <= '0;
    end else if (cfg_wr) begin
      case (word)
        W_CMD:  cmd      <= cfg_wdata[1:0];
        W_BAR0: io_bar   <= cfg_wdata[31:IO_WIN_LOG2];
        W_BAR1: mem_bar  <= cfg_wdata[31:MEM_WIN_LOG2];
        W_INT:  int_line <= cfg_wdata[7:0];
        default: ;
      endcase
    end
  end

  assign io_base      = {io_bar, {(IO_WIN_LOG2-1){1'b0}}, 1'b1};
  assign mem_base     = {mem_bar, {MEM_WIN_LOG2{1'b0}}};
  assign io_space_en  = cmd[0];
  assign mem_space_en = cmd[1];
  assign io_hit       = cmd[0] && (bus_addr[31:IO_WIN_LOG2] == io_bar);
  assign mem_hit      = cmd[1] && (bus_addr[31:MEM_WIN_LOG2] == mem_bar);

  always_comb begin
    case (word)
      W_ID:   rd_mux = {DEVICE_ID, VENDOR_ID};
      W_CMD:  rd_mux = {STATUS_WORD, 14'b0, cmd};
      W_CLS:  rd_mux = {CLASS_CODE, REVISION};
      W_BAR0: rd_mux = io_base;
      W_BAR1: rd_mux = mem_base;
      W_SUB:  rd_mux = {SUB_DEVICE, SUB_VENDOR};
      W_INT:  rd_mux = {16'h0000, INT_PIN, int_line};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk #(
  parameter int IO_WIN_LOG2  = 20,
  parameter int MEM_WIN_LOG2 = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_addr,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic        cfg_rd,
  input logic [31:0] cfg_rdata,
  input logic [31:0] bus_addr,
  input logic [31:0] io_base,
  input logic [31:0] mem_base,
  input logic        io_space_en,
  input logic        mem_space_en,
  input logic        io_hit,
  input logic        mem_hit
);
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] == 6'h00) |=> cfg_rdata == 32'h0120_1022); // R1
  AST_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[7:2] == 6'h01) |=> (io_space_en == $past(cfg_wdata[0]) && mem_space_en == $past(cfg_wdata[1]))); // R2
  AST_IO_SIZING: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[7:2] == 6'h04 && cfg_wdata == 32'hFFFF_FFFF) |=> io_base == {{(32-IO_WIN_LOG2){1'b1}}, {(IO_WIN_LOG2-1){1'b0}}, 1'b1}); // R3
  AST_MEM_SIZING: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[7:2] == 6'h05 && cfg_wdata == 32'hFFFF_FFFF) |=> mem_base == {{(32-MEM_WIN_LOG2){1'b1}}, {MEM_WIN_LOG2{1'b0}}}); // R4
  AST_IO_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !io_space_en |-> !io_hit); // R7
  AST_MEM_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_space_en |-> !mem_hit); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd && $past(rst_n)) |=> $stable(cfg_rdata)); // R9
endmodule

bind pci_cfg_space pci_cfg_space_chk #(.IO_WIN_LOG2(IO_WIN_LOG2), .MEM_WIN_LOG2(MEM_WIN_LOG2)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr), .io_base(io_base),
  .mem_base(mem_base), .io_space_en(io_space_en), .mem_space_en(mem_space_en),
  .io_hit(io_hit), .mem_hit(mem_hit));

// File: tb/test_pci_cfg_space.sv
`timescale 1ns/1ps
module test_pci_cfg_space;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wr = 0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rd = 0;
  logic [31:0] cfg_rdata;
  logic [31:0] bus_addr = '0;
  logic [31:0] io_base, mem_base;
  logic        io_space_en, mem_space_en, io_hit, mem_hit;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_cfg_space i_pci_cfg_space (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr), .io_base(io_base),
    .mem_base(mem_base), .io_space_en(io_space_en), .mem_space_en(mem_space_en),
    .io_hit(io_hit), .mem_hit(mem_hit));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; cfg_rd = 1;
    @(negedge clk); cfg_rd = 0; d = cfg_rdata;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic test_reset_state;
    chk("R10 rdata", cfg_rdata, 32'h0);
    chk("R11 enables", {30'b0, mem_space_en, io_space_en}, 32'h0);
    rdchk("R2 cmd reset", 8'h04, 32'h0400_0000);
    rdchk("R3 bar0 reset", 8'h10, 32'h0000_0001);
  endtask

  task automatic test_ids;
    rdchk("R1 id", 8'h00, 32'h0120_1022);
    rdchk("R1 class", 8'h08, 32'h0580_0001);
    rdchk("R1 zero 0C", 8'h0C, 32'h0);
    rdchk("R1 subsys", 8'h2C, 32'h0120_1022);
    wr(8'h00, 32'hDEAD_BEEF);
    rdchk("R1 id write ignored", 8'h00, 32'h0120_1022);
    rdchk("R9 low bits ignored", 8'h03, 32'h0120_1022);
  endtask

  task automatic test_sizing;
    wr(8'h10, 32'hFFFF_FFFF);
    rdchk("R3 bar0 size", 8'h10, 32'hFFF0_0001);
    chk("R11 io_base", io_base, 32'hFFF0_0001);
    wr(8'h14, 32'hFFFF_FFFF);
    rdchk("R4 bar1 size", 8'h14, 32'hFFF0_0000);
    wr(8'h10, 32'h1000_0000);
    wr(8'h14, 32'h2000_0000);
    rdchk("R3 bar0 set", 8'h10, 32'h1000_0001);
    rdchk("R4 bar1 set", 8'h14, 32'h2000_0000);
    chk("R11 mem_base", mem_base, 32'h2000_0000);
  endtask

  task automatic test_unimpl_and_int;
    rdchk("R5 int reset", 8'h3C, 32'h0000_0100);
    wr(8'h3C, 32'hFFFF_FFFF);
    rdchk("R5 int line", 8'h3C, 32'h0000_01FF);
    wr(8'h18, 32'hFFFF_FFFF);
    rdchk("R6 bar2", 8'h18, 32'h0);
    wr(8'h30, 32'h1234_5678);
    rdchk("R6 0x30", 8'h30, 32'h0);
    rdchk("R6 0x80", 8'h80, 32'h0);
    rdchk("R6 no alias bar0", 8'h10, 32'h1000_0001);
  endtask

  task automatic test_decode;
    bus_addr = 32'h1000_1234; #1;
    chk("R7 io gated off", {31'b0, io_hit}, 32'h0);
    bus_addr = 32'h2000_0010; #1;
    chk("R8 mem gated off", {31'b0, mem_hit}, 32'h0);
    wr(8'h04, 32'h0000_0003);
    rdchk("R2 cmd set", 8'h04, 32'h0400_0003);
    chk("R11 enables set", {30'b0, mem_space_en, io_space_en}, 32'h3);
    bus_addr = 32'h1000_1234; #1;
    chk("R7 io hit", {30'b0, mem_hit, io_hit}, 32'h1);
    bus_addr = 32'h100F_FFFF; #1;
    chk("R7 io top", {31'b0, io_hit}, 32'h1);
    bus_addr = 32'h1010_0000; #1;
    chk("R7 io past end", {31'b0, io_hit}, 32'h0);
    bus_addr = 32'h200A_BCDE; #1;
    chk("R8 mem hit", {30'b0, mem_hit, io_hit}, 32'h2);
    wr(8'h04, 32'h0000_0002);
    bus_addr = 32'h1000_0000; #1;
    chk("R7 io disabled", {31'b0, io_hit}, 32'h0);
    bus_addr = 32'h2000_0000; #1;
    chk("R8 mem still on", {31'b0, mem_hit}, 32'h1);
  endtask

  task automatic test_hold;
    logic [31:0] d;
    rd(8'h00, d);
    @(negedge clk); cfg_addr = 8'h14;
    repeat (3) @(negedge clk);
    chk("R9 hold", cfg_rdata, 32'h0120_1022);
  endtask

  task automatic test_reset_clear;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R10 rdata cleared", cfg_rdata, 32'h0);
    chk("R10 enables", {30'b0, mem_space_en, io_space_en}, 32'h0);
    rdchk("R10 bar0", 8'h10, 32'h0000_0001);
    rdchk("R10 bar1", 8'h14, 32'h0);
    rdchk("R10 int line", 8'h3C, 32'h0000_0100);
    rdchk("R10 cmd", 8'h04, 32'h0400_0000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    test_reset_state;
    test_ids;
    test_sizing;
    test_unimpl_and_int;
    test_decode;
    test_hold;
    test_reset_clear;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule